// File: doc/BRIEF.md
# QPSK Decision Feedback Equalizer with Differential Decoder

This block sits after the carrier mixer and low-pass filter of a QPSK receiver. It takes one signed I/Q pair per symbol and removes multipath echoes of the kind found on cable data links. Its four real-valued taps are shared by both rails. Two are feedforward taps: a precursor tap that weights the next received sample and a reference tap that weights the current one. Two are feedback taps that weight the two most recent hard decisions. The taps adapt by sign-sign LMS while the external lock input is high.

Each equalized pair is sliced to a hard QPSK decision. The quadrant change from the previous decision is differentially decoded to a Gray-coded dibit, and the two bits leave the block one after the other on a serial valid/ready stream. The equalized soft values are also available as plain outputs. Input and output both use valid/ready. A transfer happens on a rising edge where valid and ready are both high. `s_ready` is high only while the serializer is empty, so back-pressure on the bit stream stalls symbol input. A symbol offered while `s_ready` is low is not taken.

Top module: `qpsk_dfe_eq`

## Requirements
- R1: After reset, `s_ready`=1, `m_valid`=0 and `eq_i`=`eq_q`=0. The reference tap starts at unity (2^FRAC) and the other three taps at zero, so the first equalized values equal the received samples exactly.
- R2: The first symbol accepted after reset only fills the delay line and produces no output. Every later accepted symbol produces one equalized pair and exactly two serial bits.
- R3: When sample n+1 is accepted, the output for sample n is y = (c_pre·x[n+1] + c_ref·x[n] + c_fb1·d[n-1] + c_fb2·d[n-2]) >>> FRAC, arithmetic shift, saturated to DW+2 bits. This is computed separately for I and Q with the same taps.
- R4: The feedback taps take past hard decisions, not received samples. A decision component is +DEC_MAG when y ≥ 0 and -DEC_MAG when y < 0. Feedback values are zero until decisions exist.
- R5: While lock is high, each tap changes on every output by (FRAC−MU_SHIFT power of two) × (t_I + t_Q). Here t = 0 for a zero regressor and otherwise +1 when the sign of the regressor equals the sign of the slicer error (decision − y, with error ≥ 0 counted as positive), or −1 when they differ. Taps saturate at ±(2^(CW−1)−1).
- R6: While lock is low, no tap changes.
- R7: Quadrants are numbered by decision signs: (I+,Q+)=0, (I−,Q+)=1, (I−,Q−)=2, (I+,Q−)=3. The change (current − previous) mod 4 maps 0→00, 1→01, 2→11, 3→10. The previous quadrant is 0 after reset.
- R8: For each symbol, the MSB of the dibit is sent first and the LSB second.
- R9: While `m_valid`=1 and `m_ready`=0, `m_valid` and `m_bit` hold. `s_ready` is low whenever `m_valid` is high, and data offered then is ignored.
- R10: `eq_i`/`eq_q` change only when an output-producing symbol is accepted, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Adaptation enable (carrier locked) |
| s_valid | input | 1 | Input symbol valid |
| s_ready | output | 1 | Block can take a symbol |
| s_i | input | DW | Signed in-phase sample |
| s_q | input | DW | Signed quadrature sample |
| m_valid | output | 1 | Serial bit valid |
| m_ready | input | 1 | Downstream takes the bit |
| m_bit | output | 1 | Serial decoded bit |
| eq_i | output | DW+2 | Equalized in-phase soft value |
| eq_q | output | DW+2 | Equalized quadrature soft value |

## Verification
The equalized values and the first (MSB) bit appear one cycle after the rising edge that accepts the symbol. The LSB appears one cycle after the edge that hands off the MSB. `s_ready` returns one cycle after the edge that hands off the LSB. The bench drives inputs on falling edges and samples outputs on the falling edge after each of those rising edges. It compares the results with a reference model that it updates at the acceptance edge, and with a hand-worked dibit list for the differential decode. For back-pressure, it holds `m_ready` low for several falling-edge samples and then checks that the held bit, the soft values and the ignored input state stayed unchanged.

// File: rtl/qdfe_pkg.sv
package qdfe_pkg;
  localparam int NTAPS   = 4;
  localparam int TAP_PRE = 0;
  localparam int TAP_REF = 1;
  localparam int TAP_FB1 = 2;
  localparam int TAP_FB2 = 3;

  // quadrant index from decision signs: 0 (+,+) 1 (-,+) 2 (-,-) 3 (+,-)
  function automatic logic [1:0] quadrant(input logic neg_i, input logic neg_q);
    if (neg_i) return neg_q ? 2'd2 : 2'd1;
    else       return neg_q ? 2'd3 : 2'd0;
  endfunction

  // phase step (units of 90 deg) to Gray dibit
  function automatic logic [1:0] gray_dibit(input logic [1:0] step);
    return {step[1], step[1] ^ step[0]};
  endfunction
endpackage

// File: rtl/qdfe_fir.sv
module qdfe_fir
  import qdfe_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CW      = 12,
  parameter int FRAC    = 8,
  parameter int YW      = 10,
  parameter int DEC_MAG = 64
) (
  input  logic [NTAPS-1:0][CW-1:0] coef,
  input  logic [NTAPS-1:0][DW-1:0] rx,
  output logic signed [YW-1:0]     y,
  output logic                     dec_neg,
  output logic                     err_neg
);
  localparam int ACCW = CW + DW + 2;
  localparam logic signed [ACCW-1:0] YMAX = ACCW'((2 ** (YW - 1)) - 1);
  localparam logic signed [ACCW-1:0] YMIN = ACCW'(-(2 ** (YW - 1)));

  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] shf;
  logic signed [YW:0]     dec_w;
  logic signed [YW:0]     err;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc = acc + ACCW'($signed(coef[k])) * ACCW'($signed(rx[k]));
    end
    shf = acc >>> FRAC;
    if (shf > YMAX)      y = YW'(YMAX);
    else if (shf < YMIN) y = YW'(YMIN);
    else                 y = YW'(shf);
  end

  assign dec_neg = y[YW-1];

  always_comb begin
    dec_w = dec_neg ? -(YW+1)'(DEC_MAG) : (YW+1)'(DEC_MAG);
    err   = dec_w - {y[YW-1], y};
  end

  assign err_neg = err[YW];
endmodule

// File: rtl/qdfe_coef.sv
module qdfe_coef
  import qdfe_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CW       = 12,
  parameter int FRAC     = 8,
  parameter int MU_SHIFT = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd,
  input  logic [NTAPS-1:0][DW-1:0] rx_i,
  input  logic [NTAPS-1:0][DW-1:0] rx_q,
  input  logic                     err_neg_i,
  input  logic                     err_neg_q,
  output logic [NTAPS-1:0][CW-1:0] coef
);
  localparam int SW    = CW + 3;
  localparam int DELTA = 2 ** (FRAC - MU_SHIFT);
  localparam int UNITY = 2 ** FRAC;
  localparam logic signed [SW-1:0] CMAX = SW'((2 ** (CW - 1)) - 1);
  localparam logic signed [SW-1:0] CMIN = -CMAX;

  // sign(regressor) * sign(error), zero regressor gives zero
  function automatic logic signed [2:0] dir(input logic [DW-1:0] x, input logic eneg);
    if (x == '0)             return 3'sd0;
    else if (x[DW-1] ^ eneg) return -3'sd1;
    else                     return 3'sd1;
  endfunction

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [CW-1:0] INIT = (k == TAP_REF) ? CW'(UNITY) : '0;
    logic signed [CW-1:0] c_q;
    logic signed [2:0]    st;
    logic signed [SW-1:0] cand;
    logic signed [SW-1:0] cand_sat;

    always_comb begin
      st   = dir(rx_i[k], err_neg_i) + dir(rx_q[k], err_neg_q);
      cand = SW'(c_q) + SW'(st) * SW'(DELTA);
      if (cand > CMAX)      cand_sat = CMAX;
      else if (cand < CMIN) cand_sat = CMIN;
      else                  cand_sat = cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   c_q <= INIT;
      else if (upd) c_q <= CW'(cand_sat);
    end

    assign coef[k] = c_q;
  end
endmodule

// File: rtl/qdfe_diffdec.sv
module qdfe_diffdec
  import qdfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       neg_i,
  input  logic       neg_q,
  output logic [1:0] dibit
);
  logic [1:0] prev_q;
  logic [1:0] cur_q;

  assign cur_q = quadrant(neg_i, neg_q);
  assign dibit = gray_dibit(cur_q - prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 2'd0;
    else if (load) prev_q <= cur_q;
  end
endmodule

// File: rtl/qdfe_ser.sv
module qdfe_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] dibit,
  input  logic       m_ready,
  output logic       m_valid,
  output logic       m_bit,
  output logic       idle
);
  logic pend;
  logic lo_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_bit   <= 1'b0;
      pend    <= 1'b0;
      lo_bit  <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_bit   <= dibit[1];
      lo_bit  <= dibit[0];
      pend    <= 1'b1;
    end else if (m_valid && m_ready) begin
      if (pend) begin
        m_bit <= lo_bit;
        pend  <= 1'b0;
      end else begin
        m_valid <= 1'b0;
      end
    end
  end

  assign idle = !m_valid;
endmodule

// File: rtl/qpsk_dfe_eq.sv
module qpsk_dfe_eq #(
  parameter int DW       = 8,
  parameter int CW       = 12,
  parameter int FRAC     = 8,
  parameter int MU_SHIFT = 6,
  parameter int DEC_MAG  = 64,
  localparam int YW      = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock_i,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DW-1:0]        s_i,
  input  logic [DW-1:0]        s_q,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic                 m_bit,
  output logic signed [YW-1:0] eq_i,
  output logic signed [YW-1:0] eq_q
);
  import qdfe_pkg::*;

  localparam logic signed [DW-1:0] DPOS = DW'(DEC_MAG);
  localparam logic signed [DW-1:0] DNEG = -DW'(DEC_MAG);

  logic accept, fire, upd, idle;
  logic have_cur;
  logic signed [DW-1:0] xc_i, xc_q, d1_i, d1_q, d2_i, d2_q;
  logic [NTAPS-1:0][DW-1:0] rx_i, rx_q;
  logic [NTAPS-1:0][CW-1:0] coef;
  logic signed [YW-1:0] y_i, y_q;
  logic dec_neg_i, dec_neg_q, err_neg_i, err_neg_q;
  logic [1:0] dibit;

  assign s_ready = idle;
  assign accept  = s_valid && s_ready;
  assign fire    = accept && have_cur;
  assign upd     = fire && lock_i;

  always_comb begin
    rx_i[TAP_PRE] = s_i;
    rx_i[TAP_REF] = xc_i;
    rx_i[TAP_FB1] = d1_i;
    rx_i[TAP_FB2] = d2_i;
    rx_q[TAP_PRE] = s_q;
    rx_q[TAP_REF] = xc_q;
    rx_q[TAP_FB1] = d1_q;
    rx_q[TAP_FB2] = d2_q;
  end

  qdfe_fir #(.DW(DW), .CW(CW), .FRAC(FRAC), .YW(YW), .DEC_MAG(DEC_MAG)) u_fir_i (
    .coef(coef), .rx(rx_i), .y(y_i), .dec_neg(dec_neg_i), .err_neg(err_neg_i)
  );

  qdfe_fir #(.DW(DW), .CW(CW), .FRAC(FRAC), .YW(YW), .DEC_MAG(DEC_MAG)) u_fir_q (
    .coef(coef), .rx(rx_q), .y(y_q), .dec_neg(dec_neg_q), .err_neg(err_neg_q)
  );

  qdfe_coef #(.DW(DW), .CW(CW), .FRAC(FRAC), .MU_SHIFT(MU_SHIFT)) u_coef (
    .clk(clk), .rst_n(rst_n), .upd(upd), .rx_i(rx_i), .rx_q(rx_q),
    .err_neg_i(err_neg_i), .err_neg_q(err_neg_q), .coef(coef)
  );

  qdfe_diffdec u_dd (
    .clk(clk), .rst_n(rst_n), .load(fire),
    .neg_i(dec_neg_i), .neg_q(dec_neg_q), .dibit(dibit)
  );

  qdfe_ser u_ser (
    .clk(clk), .rst_n(rst_n), .load(fire), .dibit(dibit), .m_ready(m_ready),
    .m_valid(m_valid), .m_bit(m_bit), .idle(idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_cur <= 1'b0;
      xc_i <= '0; xc_q <= '0;
      d1_i <= '0; d1_q <= '0;
      d2_i <= '0; d2_q <= '0;
      eq_i <= '0; eq_q <= '0;
    end else if (accept) begin
      xc_i     <= s_i;
      xc_q     <= s_q;
      have_cur <= 1'b1;
      if (have_cur) begin
        d2_i <= d1_i;
        d2_q <= d1_q;
        d1_i <= dec_neg_i ? DNEG : DPOS;
        d1_q <= dec_neg_q ? DNEG : DPOS;
        eq_i <= y_i;
        eq_q <= y_q;
      end
    end
  end
endmodule

// File: rtl/qdfe_checker.sv
module qdfe_checker
  import qdfe_pkg::*;
#(
  parameter int CW       = 12,
  parameter int FRAC     = 8,
  parameter int MU_SHIFT = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lock_i,
  input logic                     s_valid,
  input logic                     s_ready,
  input logic                     m_valid,
  input logic                     m_ready,
  input logic                     m_bit,
  input logic [NTAPS-1:0][CW-1:0] coef
);
  localparam int STEP2 = 2 * (2 ** (FRAC - MU_SHIFT));

  assert_hold_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit)));

  assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  assert_out_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready));

  assert_frozen_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> $stable(coef));

  for (genvar k = 0; k < NTAPS; k++) begin : g_step
    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'($signed(coef[k])) - int'($signed($past(coef[k])))) <= STEP2) &&
      ((int'($signed(coef[k])) - int'($signed($past(coef[k])))) >= -STEP2));
  end
endmodule

bind qpsk_dfe_eq qdfe_checker #(.CW(CW), .FRAC(FRAC), .MU_SHIFT(MU_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit), .coef(coef)
);

// File: tb/tb_qpsk_dfe_eq.sv
`timescale 1ns/1ps
module tb_qpsk_dfe_eq;
  localparam int DW = 8;
  localparam int YW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_i = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [DW-1:0] s_i = '0;
  logic [DW-1:0] s_q = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic m_bit;
  logic signed [YW-1:0] eq_i, eq_q;

  always #10 clk = ~clk;

  qpsk_dfe_eq dut (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit),
    .eq_i(eq_i), .eq_q(eq_q)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  int mc[4];
  int mxi, mxq, md1i, md1q, md2i, md2q, mprev;
  bit mhave;
  bit exp_out;
  int exp_yi, exp_yq;
  logic [1:0] exp_code;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int sdir(input int x, input bit eneg);
    if (x == 0) return 0;
    return ((x < 0) != eneg) ? -1 : 1;
  endfunction

  function automatic int quad(input bit ni, input bit nq);
    if (!ni && !nq) return 0;
    if (ni && !nq)  return 1;
    if (ni && nq)   return 2;
    return 3;
  endfunction

  function automatic logic [1:0] step_code(input int st);
    case (st)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic model_reset();
    mc = '{0, 256, 0, 0};
    mxi = 0; mxq = 0; md1i = 0; md1q = 0; md2i = 0; md2q = 0; mprev = 0;
    mhave = 1'b0;
  endtask

  task automatic model_accept(input int ni, input int nq);
    int ri[4];
    int rq[4];
    int ai, aq, yi, yq, di, dq, qn;
    bit ngi, ngq, eni, enq;
    exp_out = mhave;
    if (mhave) begin
      ri = '{ni, mxi, md1i, md2i};
      rq = '{nq, mxq, md1q, md2q};
      ai = 0; aq = 0;
      for (int k = 0; k < 4; k++) begin
        ai += mc[k] * ri[k];
        aq += mc[k] * rq[k];
      end
      yi = sat(ai >>> 8, -512, 511);
      yq = sat(aq >>> 8, -512, 511);
      ngi = (yi < 0); ngq = (yq < 0);
      di = ngi ? -64 : 64; dq = ngq ? -64 : 64;
      eni = ((di - yi) < 0); enq = ((dq - yq) < 0);
      qn = quad(ngi, ngq);
      exp_code = step_code((qn - mprev) & 3);
      exp_yi = yi; exp_yq = yq;
      if (lock_i) begin
        for (int k = 0; k < 4; k++)
          mc[k] = sat(mc[k] + 4 * (sdir(ri[k], eni) + sdir(rq[k], enq)), -2047, 2047);
      end
      md2i = md1i; md2q = md1q; md1i = di; md1q = dq; mprev = qn;
    end
    mxi = ni; mxq = nq; mhave = 1'b1;
  endtask

  // call at a falling edge; returns at a falling edge
  task automatic send_sym(input int vi, input int vq);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_i = vi[DW-1:0]; s_q = vq[DW-1:0];
    @(posedge clk);
    model_accept(vi, vq);
    @(negedge clk);
    s_valid = 1'b0;
    if (exp_out) begin
      chk(m_valid === 1'b1, "R2 bits after symbol", int'(m_valid), 1);
      chk(eq_i == exp_yi, "R3 R4 R5 eq_i", int'(eq_i), exp_yi);
      chk(eq_q == exp_yq, "R3 R4 R5 eq_q", int'(eq_q), exp_yq);
      chk(m_bit === exp_code[1], "R7 R8 first bit", int'(m_bit), int'(exp_code[1]));
      if (m_ready) begin
        @(negedge clk);
        chk(m_bit === exp_code[0], "R7 R8 second bit", int'(m_bit), int'(exp_code[0]));
        chk(m_valid === 1'b1, "R2 second bit valid", int'(m_valid), 1);
        @(negedge clk);
        chk(m_valid === 1'b0, "R2 only two bits", int'(m_valid), 0);
        chk(s_ready === 1'b1, "R9 ready after bits", int'(s_ready), 1);
      end
    end else begin
      chk(m_valid === 1'b0, "R2 first symbol silent", int'(m_valid), 0);
      @(negedge clk);
      chk(m_valid === 1'b0, "R2 first symbol silent later", int'(m_valid), 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; lock_i = 1'b0; m_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(s_ready === 1'b1, "R1 s_ready at reset", int'(s_ready), 1);
    chk(m_valid === 1'b0, "R1 m_valid at reset", int'(m_valid), 0);
    chk(eq_i == 0 && eq_q == 0, "R1 soft zero at reset", int'(eq_i), 0);
  endtask

  task automatic t_unity();
    do_reset();
    send_sym(30, -20);
    send_sym(5, 5);
    chk(eq_i == 30, "R1 unity ref tap I", int'(eq_i), 30);
    chk(eq_q == -20, "R1 unity ref tap Q", int'(eq_q), -20);
    send_sym(-100, 90);
    send_sym(0, 0);
    chk(eq_i == -100, "R1 unity ref tap I2", int'(eq_i), -100);
  endtask

  task automatic t_diffdec();
    int qi[9] = '{40, -40, -40, 40, 40, -40, 40, -40, 10};
    int qq[9] = '{40, 40, -40, -40, -40, 40, 40, -40, 10};
    logic [1:0] hand[8] = '{2'b00, 2'b01, 2'b01, 2'b01, 2'b00, 2'b11, 2'b10, 2'b11};
    do_reset();
    send_sym(qi[0], qq[0]);
    for (int n = 1; n < 9; n++) begin
      send_sym(qi[n], qq[n]);
      chk(exp_code == hand[n-1], "R7 hand dibit", int'(exp_code), int'(hand[n-1]));
    end
  endtask

  task automatic t_adapt_freeze();
    int sy[170];
    int seed = 7;
    int xi, xq;
    do_reset();
    for (int n = 0; n < 170; n++) begin
      seed = seed * 1103515245 + 12345;
      sy[n] = seed[16] ? 50 : -50;
    end
    lock_i = 1'b1;
    for (int n = 1; n < 168; n++) begin
      if (n == 110) lock_i = 1'b0;  // R6 freeze for the remainder
      xi = sy[n] + (sy[n-1] * 3) / 8 - sy[n+1] / 8;
      xq = sy[n+1] - (sy[n] * 3) / 8 + sy[n-1] / 8;
      send_sym(xi, xq);
    end
    lock_i = 1'b0;
  endtask

  task automatic t_backpressure();
    int hold_i, hold_q;
    do_reset();
    send_sym(20, 20);
    m_ready = 1'b0;
    send_sym(-20, 20);
    hold_i = int'(eq_i); hold_q = int'(eq_q);
    s_valid = 1'b1; s_i = 8'd99; s_q = 8'd99;  // must be ignored
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(m_valid === 1'b1, "R9 valid held", int'(m_valid), 1);
      chk(m_bit === exp_code[1], "R9 bit held", int'(m_bit), int'(exp_code[1]));
      chk(s_ready === 1'b0, "R9 not ready while busy", int'(s_ready), 0);
      chk(eq_i == hold_i && eq_q == hold_q, "R10 soft held", int'(eq_i), hold_i);
    end
    s_valid = 1'b0;
    m_ready = 1'b1;
    @(negedge clk);
    chk(m_bit === exp_code[0], "R8 R9 second bit after stall", int'(m_bit), int'(exp_code[0]));
    @(negedge clk);
    chk(m_valid === 1'b0, "R9 drained", int'(m_valid), 0);
    repeat (3) @(negedge clk);
    chk(eq_i == hold_i, "R10 soft held idle", int'(eq_i), hold_i);
    send_sym(-20, -20);  // model assumes ignored data never entered
    send_sym(20, -20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    t_reset_state();
    t_unity();
    t_diffdec();
    t_adapt_freeze();
    t_backpressure();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule